// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a single-bit signal by a programmable number of clock cycles. The delay is the sum of a fixed base latency and an added amount chosen by a ten-bit code. The code bits are weighted in powers of two, so the added delay equals the binary value of the code. An override input can force the least delay, and another can force a delay one unit longer than the all-ones code. When both overrides are high, the least-delay override wins. A mute input forces the output low.

The code passes through a load/hold register. While the hold input is low, a new code takes effect at once. While hold is high, the block keeps the code it held at the last clock edge where hold was low. An eleventh code bit shares that register and drives a complementary pair of chain outputs. The chain outputs are meant for the override inputs of a following stage. When the eleventh bit is clear, the next stage sits at its least delay. When the bit is set, the next stage sits at its largest delay. This keeps the combined delay continuous across the boundary between the two stages.

One delay unit is one clock cycle. A bit sampled on `sig_in` at edge m appears on `sig_out` just after edge m + BASE_LAT + units.

Top module: `prog_delay_line`

## Requirements
- R1: Code bits 9 down to 0 add 512, 256, 128, 64, 32, 16, 8, 4, 2 and 1 cycles respectively. A bit sampled on `sig_in` at edge m appears on `sig_out` after edge m + BASE_LAT + code.
- R2: A code of 0 gives a total delay of exactly BASE_LAT cycles (default 4). A code of 1023 gives BASE_LAT + 1023 cycles.
- R3: While `code_hold` is low, the value on `dly_code` is used at the same edge it is presented.
- R4: While `code_hold` is high, changes on `dly_code` have no effect. The block uses the code present at the last edge where `code_hold` was low.
- R5: `force_min` high selects 0 added cycles and drives `chain_hi` low, whatever the eleven code bits are.
- R6: `force_max` high with `force_min` low selects 1024 added cycles and drives `chain_hi` high, whatever the code is.
- R7: With both overrides high, the least delay (0 added cycles) is used.
- R8: `mute` sampled high at an edge makes `sig_out` low after that edge. `mute` sampled low lets the delayed bit through.
- R9: `chain_hi` equals code bit 10 after the load/hold register, and `chain_lo` is always its complement.
- R10: Synchronous active-high `rst` clears the held code to zero, empties the delay store to zeros and drives `sig_out` low. After reset, no earlier input reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one cycle is one delay unit |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Bit stream to delay |
| dly_code | input | 11 | Bits 9:0 select the added delay; bit 10 is the chain bit |
| code_hold | input | 1 | Low: code passes through; high: the held code is kept |
| force_min | input | 1 | Forces the least delay; has priority |
| force_max | input | 1 | Forces 1024 added cycles |
| mute | input | 1 | High forces `sig_out` low |
| sig_out | output | 1 | Delayed (registered) bit |
| chain_hi | output | 1 | True chain output for the next stage |
| chain_lo | output | 1 | Complement chain output |

## Verification
Several internal faults show up at `sig_out` as a pulse that arrives early or late: a wrong weight on one code bit, a wrong tap index or a broken override priority. The shift is the size of the faulty weight, or one cycle for an off-by-one tap. The fault appears once the tap is read, which can be up to BASE_LAT + 1024 cycles after the bit was sampled. A held code that is lost or updated while `code_hold` is high shows as a delay change on the next bit that crosses the tap. It also shows at once as a wrong level on `chain_hi` when bit 10 differs. A mute or reset fault shows one edge later as a stray high on `sig_out`.

// File: rtl/dly_pkg.sv
package dly_pkg;
  // Which source decides the added delay.
  typedef enum logic [1:0] {
    SEL_CODE = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_MAX  = 2'd2
  } sel_mode_e;

  // Override priority: minimum beats maximum, both beat the code.
  function automatic sel_mode_e pick_mode(input logic fmin, input logic fmax);
    if (fmin)      return SEL_MIN;
    else if (fmax) return SEL_MAX;
    else           return SEL_CODE;
  endfunction
endpackage

// File: rtl/dly_code_latch.sv
module dly_code_latch #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)          held_q <= '0;
    else if (!hold_i) held_q <= code_i;
  end

  // Transparent while open, held value while closed.
  assign eff_o = hold_i ? held_q : code_i;

  // R4
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(held_q));

  // R3
  held_tracks_chk: assert property (@(posedge clk) disable iff (rst)
    !hold_i |=> held_q == $past(code_i));
endmodule

// File: rtl/dly_sel_decode.sv
module dly_sel_decode
  import dly_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic            fmin_i,
  input  logic            fmax_i,
  input  logic [CODE_W:0] code_i,
  output logic [CODE_W:0] units_o,
  output logic            chain_o
);
  localparam int UW = CODE_W + 1;
  localparam logic [UW-1:0] MAX_UNITS = UW'(1) << CODE_W;

  function automatic logic [UW-1:0] units_of(input sel_mode_e m,
                                             input logic [CODE_W-1:0] c);
    case (m)
      SEL_MIN: return '0;
      SEL_MAX: return MAX_UNITS;
      default: return {1'b0, c};
    endcase
  endfunction

  function automatic logic chain_of(input sel_mode_e m, input logic b);
    case (m)
      SEL_MIN: return 1'b0;
      SEL_MAX: return 1'b1;
      default: return b;
    endcase
  endfunction

  sel_mode_e mode_w;

  always_comb begin
    mode_w  = pick_mode(fmin_i, fmax_i);
    units_o = units_of(mode_w, code_i[CODE_W-1:0]);
    chain_o = chain_of(mode_w, code_i[CODE_W]);
  end
endmodule

// File: rtl/dly_tap_line.sv
module dly_tap_line #(
  parameter int BASE_LAT = 4,
  parameter int CODE_W   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din_i,
  input  logic [CODE_W:0] units_i,
  output logic            tap_o
);
  localparam int DEPTH = BASE_LAT + (1 << CODE_W);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [CODE_W:0] MAX_UNITS = (CODE_W+1)'(1) << CODE_W;

  logic [DEPTH-1:0] sr_q;
  logic [IDX_W-1:0] idx_w;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else     sr_q <= {sr_q[DEPTH-2:0], din_i};
  end

  // The output register adds one cycle, so read one entry short.
  assign idx_w = IDX_W'(BASE_LAT - 1) + IDX_W'(units_i);
  assign tap_o = sr_q[idx_w];

  // R1
  store_entry_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sr_q[0] == $past(din_i));

  // R6
  units_range_chk: assert property (@(posedge clk) disable iff (rst)
    units_i <= MAX_UNITS);
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int BASE_LAT = 4,
  parameter int CODE_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_in,
  input  logic [CODE_W:0]   dly_code,
  input  logic              code_hold,
  input  logic              force_min,
  input  logic              force_max,
  input  logic              mute,
  output logic              sig_out,
  output logic              chain_hi,
  output logic              chain_lo
);
  localparam logic [CODE_W:0] MAX_UNITS = (CODE_W+1)'(1) << CODE_W;

  logic [CODE_W:0] eff_code_w;
  logic [CODE_W:0] units_w;
  logic            chain_w;
  logic            tap_w;
  logic            out_q;

  dly_code_latch #(.W(CODE_W + 1)) u_latch (
    .clk(clk), .rst(rst), .hold_i(code_hold),
    .code_i(dly_code), .eff_o(eff_code_w)
  );

  dly_sel_decode #(.CODE_W(CODE_W)) u_dec (
    .fmin_i(force_min), .fmax_i(force_max), .code_i(eff_code_w),
    .units_o(units_w), .chain_o(chain_w)
  );

  dly_tap_line #(.BASE_LAT(BASE_LAT), .CODE_W(CODE_W)) u_line (
    .clk(clk), .rst(rst), .din_i(sig_in),
    .units_i(units_w), .tap_o(tap_w)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= mute ? 1'b0 : tap_w;
  end

  assign sig_out  = out_q;
  assign chain_hi = chain_w;
  assign chain_lo = ~chain_w;

  // R8
  mute_low_chk: assert property (@(posedge clk) disable iff (rst)
    mute |=> !sig_out);

  // R9
  chain_pair_chk: assert property (@(posedge clk) disable iff (rst)
    chain_hi != chain_lo);

  // R7
  min_wins_chk: assert property (@(posedge clk) disable iff (rst)
    force_min |-> (units_w == '0 && !chain_hi));

  // R6
  max_units_chk: assert property (@(posedge clk) disable iff (rst)
    (force_max && !force_min) |-> (units_w == MAX_UNITS && chain_hi));

  // R10
  reset_out_chk: assert property (@(posedge clk)
    rst |=> !sig_out);
endmodule

// File: tb/prog_delay_line_test.sv
module prog_delay_line_test;
  localparam int CLK_NS = 10;
  localparam int BASE   = 4;
  localparam int CW     = 10;
  localparam int DEPTH  = BASE + (1 << CW);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic [CW:0] code = '0;
  logic hold = 1'b0, fmin = 1'b0, fmax = 1'b0, mute = 1'b0;
  logic dout, c_hi, c_lo;

  int nrun = 0, nfail = 0;
  bit hb [DEPTH];
  logic [CW:0] mheld = '0;

  always #(CLK_NS/2) clk = ~clk;

  prog_delay_line #(.BASE_LAT(BASE), .CODE_W(CW)) uut (
    .clk(clk), .rst(rst), .sig_in(din), .dly_code(code), .code_hold(hold),
    .force_min(fmin), .force_max(fmax), .mute(mute),
    .sig_out(dout), .chain_hi(c_hi), .chain_lo(c_lo)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Added cycles from the requirements: min beats max, both beat the code.
  function automatic int want_units(input logic mn, input logic mx, input logic [CW:0] c);
    if (mn) return 0;
    if (mx) return 1 << CW;
    return int'(c[CW-1:0]);
  endfunction

  function automatic logic want_chain(input logic mn, input logic mx, input logic [CW:0] c);
    if (mn) return 1'b0;
    if (mx) return 1'b1;
    return c[CW];
  endfunction

  task automatic tick(input string tag);
    logic exp_q;
    logic [CW:0] eff;
    logic ch;
    if (rst) exp_q = 1'b0;
    else begin
      eff = hold ? mheld : code;
      exp_q = mute ? 1'b0 : hb[BASE + want_units(fmin, fmax, eff) - 1];
    end
    @(posedge clk); #1;
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) hb[j] = 1'b0;
      mheld = '0;
    end else begin
      for (int j = DEPTH-1; j > 0; j--) hb[j] = hb[j-1];
      hb[0] = din;
      if (!hold) mheld = code;
    end
    chk(tag, dout, exp_q);
    if (!rst) begin
      eff = hold ? mheld : code;
      ch = want_chain(fmin, fmax, eff);
      chk(fmin ? "R5" : (fmax ? "R6" : "R9"), c_hi, ch);
      chk("R9", c_lo, ~ch);
    end
  endtask

  task automatic pulse_run(input string tag, input int n);
    din = 1'b1; tick(tag);
    din = 1'b0;
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic rand_run(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      din = 1'($urandom);
      tick(tag);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1957));
    // R10: reset state, then reset in the middle of a busy store
    for (int i = 0; i < 3; i++) tick("R10");
    rst = 1'b0;
    code = 11'd6;
    for (int i = 0; i < 8; i++) begin din = 1'b1; tick("R10"); end
    rst = 1'b1; din = 1'b1; code = 11'h7ff; hold = 1'b1; tick("R10");
    rst = 1'b0; hold = 1'b0; din = 1'b0; code = 11'd6;
    for (int i = 0; i < 20; i++) tick("R10");
    // R2: extremes of the code
    code = 11'd0;    pulse_run("R2", BASE + 4);
    code = 11'd1023; pulse_run("R2", BASE + 1026);
    // R1: single weights and a mix
    code = 11'd512; pulse_run("R1", BASE + 515);
    code = 11'd1;   pulse_run("R1", BASE + 4);
    code = 11'd37;  pulse_run("R1", BASE + 40);
    // R3: transparent code changes every cycle
    for (int i = 0; i < 300; i++) begin
      code = 11'($urandom_range(0, 63)); din = 1'($urandom); tick("R3");
    end
    // R4: hold closed, code keeps moving
    code = 11'd100; tick("R4");
    hold = 1'b1;
    for (int i = 0; i < 300; i++) begin
      code = 11'($urandom); din = 1'($urandom); tick("R4");
    end
    hold = 1'b0;
    // R6: forced maximum, including the hold register set to all ones
    code = 11'h3ff; fmax = 1'b1; pulse_run("R6", BASE + 1027);
    // R7: both overrides
    fmin = 1'b1; rand_run("R7", 60);
    // R5: minimum alone with chain bit set
    fmax = 1'b0; code = 11'h7ff; rand_run("R5", 40);
    fmin = 1'b0;
    // R8: mute toggling over a busy stream
    code = 11'd9;
    for (int i = 0; i < 200; i++) begin
      mute = 1'($urandom); din = 1'($urandom); tick("R8");
    end
    mute = 1'b0;
    // R9: chain bit through open and closed hold
    code = 11'h400; tick("R9");
    hold = 1'b1; code = 11'h000; tick("R9"); tick("R9");
    hold = 1'b0; tick("R9");
    // Mixed random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8)  code = 11'($urandom);
      else if (r < 12) code = 11'($urandom_range(0, 31));
      if ($urandom_range(0, 49) == 0) hold = ~hold;
      fmin = ($urandom_range(0, 29) == 0);
      fmax = ($urandom_range(0, 19) == 0);
      mute = ($urandom_range(0, 9) == 0);
      din  = 1'($urandom);
      tick(fmin ? (fmax ? "R7" : "R5") : fmax ? "R6" : mute ? "R8" : hold ? "R4" : "R1");
    end
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule